// File: doc/BRIEF.md
# Bus Request and Parking Controller

This block is the master-side ownership control for one bus port of a bridge. When the bridge has a transaction waiting, the block raises an active-low request toward the bus arbiter. It watches the active-low grant that comes back, and it issues a one-clock frame-start pulse on the clock after it sees the grant on an idle bus. A strap input moves the request and grant onto a second pair of pins so that an external arbiter can be used. In that mode the normal request pin is held inactive and the normal grant pin is not used.

When the port holds a grant it did not ask for and the bus is idle, the block parks the bus. It first enables the address/data and command/byte-enable drivers, and it enables the parity driver one clock later. When the grant goes away, every driver is switched off on the next clock. If a transaction becomes pending while the port is parked and still granted, the frame-start pulse follows on the next clock without any request being raised. All outputs are registered. Data values, parity generation and the later phases of a transaction are handled elsewhere.

Top module: `bus_park_ctl`

## Requirements
- R1: While reset is high, and on the first clock after it, both request pins are high, both driver enables are low and the frame-start pulse is low.
- R2: A pending transaction with no grant drives the selected request pin low on the next clock, and the pin stays low while the grant stays absent.
- R3: When the request is low and the grant is seen on an idle bus, the frame-start pulse is high for exactly one clock on the next clock, and the request goes high in that same clock.
- R4: If the grant is withdrawn, or the bus is busy, before a start has been issued, the request stays low and no frame-start pulse appears until a grant is seen on an idle bus.
- R5: With the grant present, the port's own request high and the bus idle, the address/data and command enable goes high on the next clock.
- R6: The parity enable goes high one clock after the address/data enable has gone high, and it is never high while that enable is low.
- R7: When the grant is deasserted, both driver enables are low on the next clock.
- R8: No driver enable is raised while the bus is busy or while the port's own request is low.
- R9: From the parked state, a newly pending transaction with the grant still present gives a frame-start pulse on the next clock, and the request pin stays high.
- R10: With the strap high, the request goes out on the alternate request pin and the grant is taken from the alternate grant pin. The normal request pin stays high and the normal grant pin has no effect. With the strap low, the alternate request pin stays high.
- R11: After a frame-start pulse, no further request or frame-start pulse is produced until the pending input has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_arb_i | input | 1 | Strap: 1 selects external-arbiter pin mapping |
| pend_i | input | 1 | Internal transaction pending (level) |
| gnt_n_i | input | 1 | Active-low grant, normal pin |
| alt_gnt_n_i | input | 1 | Active-low grant, alternate pin (external-arbiter mode) |
| idle_i | input | 1 | High when the bus is idle |
| req_n_o | output | 1 | Active-low request, normal pin |
| alt_req_n_o | output | 1 | Active-low request, alternate pin (external-arbiter mode) |
| ad_oe_o | output | 1 | Output enable for the address/data and command/byte-enable group |
| par_oe_o | output | 1 | Output enable for the parity line |
| frame_go_o | output | 1 | One-clock frame-start pulse |

## Verification
The hardest case to reach is a start made straight from the parked state while parity is already being driven. The port must first hold an unrequested grant on an idle bus for two clocks so that both enables are up. Only then does the pending input rise, with the grant still present, and the bench checks for the frame-start pulse with the request pin still high. The stimulus table builds up that state row by row. It then takes the grant away, so the same sequence also checks that the drivers switch off one clock later.

// File: rtl/bus_park_pkg.sv
package bus_park_pkg;

    // Driver enables for the parked bus.
    typedef struct packed {
        logic ad;   // address/data + command/byte-enable group
        logic par;  // parity line
    } drv_en_t;

    localparam drv_en_t DRV_OFF = '{ad: 1'b0, par: 1'b0};

    // Effective (active-high) grant taken from the pin chosen by the strap.
    function automatic logic pick_grant(input logic ext_mode,
                                        input logic gnt_n,
                                        input logic alt_gnt_n);
        return ext_mode ? ~alt_gnt_n : ~gnt_n;
    endfunction

endpackage

// File: rtl/bpc_grant_sel.sv
module bpc_grant_sel
    import bus_park_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_arb_i,
    input  logic gnt_n_i,
    input  logic alt_gnt_n_i,
    input  logic req_i,
    output logic granted_o,
    output logic req_n_o,
    output logic alt_req_n_o
);

    assign granted_o   = pick_grant(ext_arb_i, gnt_n_i, alt_gnt_n_i);
    assign req_n_o     = ext_arb_i ? 1'b1 : ~req_i;
    assign alt_req_n_o = ext_arb_i ? ~req_i : 1'b1;

    // Only one request pin can ever be active.
    assert_one_req_pin_R10: assert property (@(posedge clk) disable iff (rst)
        (req_n_o || alt_req_n_o));

    // In external mode the normal grant pin never makes the port granted.
    assert_ext_grant_src_R10: assert property (@(posedge clk) disable iff (rst)
        (ext_arb_i && alt_gnt_n_i) |-> !granted_o);

endmodule

// File: rtl/bpc_req_ctl.sv
module bpc_req_ctl (
    input  logic clk,
    input  logic rst,
    input  logic granted_i,
    input  logic idle_i,
    input  logic pend_i,
    output logic req_o,
    output logic frame_go_o
);

    logic req_q;
    logic frame_q;
    logic done_q;
    logic start_d;

    // A start needs ownership, an idle bus and work not yet started.
    assign start_d = granted_i && idle_i && pend_i && !done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            frame_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            req_q   <= pend_i && !done_q && !start_d;
            frame_q <= start_d;
            done_q  <= pend_i && (done_q || start_d);
        end
    end

    assign req_o      = req_q;
    assign frame_go_o = frame_q;

    // Start pulse lasts a single clock.
    assert_frame_one_clk_R11: assert property (@(posedge clk) disable iff (rst)
        frame_q |=> !frame_q);

    // Without ownership there is no start on the following clock.
    assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
        !granted_i |=> !frame_q);

    // Request is never held in the clock the start is issued.
    assert_req_drops_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        frame_q |-> !req_q);

    // A lost grant keeps a pending request alive.
    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (req_q && pend_i && !granted_i) |=> req_q);

endmodule

// File: rtl/bpc_park_ctl.sv
module bpc_park_ctl
    import bus_park_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    granted_i,
    input  logic    idle_i,
    input  logic    req_i,
    output drv_en_t drv_o
);

    drv_en_t drv_q;
    logic    park_ok;

    assign park_ok = granted_i && !req_i && idle_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= DRV_OFF;
        end else begin
            drv_q.ad  <= park_ok;
            drv_q.par <= park_ok && drv_q.ad;
        end
    end

    assign drv_o = drv_q;

    // Parity never driven without the address/data group.
    assert_par_needs_ad_R6: assert property (@(posedge clk) disable iff (rst)
        drv_q.par |-> drv_q.ad);

    // Address/data comes up a clock before parity.
    assert_ad_leads_par_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_q.ad) |-> !drv_q.par);

    // Grant loss releases every driver on the next clock.
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        !granted_i |=> (drv_q == DRV_OFF));

    // Own request or busy bus blocks parking.
    assert_no_park_R8: assert property (@(posedge clk) disable iff (rst)
        (req_i || !idle_i) |=> !drv_q.ad);

endmodule

// File: rtl/bus_park_ctl.sv
module bus_park_ctl
    import bus_park_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_arb_i,
    input  logic pend_i,
    input  logic gnt_n_i,
    input  logic alt_gnt_n_i,
    input  logic idle_i,
    output logic req_n_o,
    output logic alt_req_n_o,
    output logic ad_oe_o,
    output logic par_oe_o,
    output logic frame_go_o
);

    logic    granted;
    logic    req;
    drv_en_t drv;

    bpc_grant_sel u_grant_sel (
        .clk         (clk),
        .rst         (rst),
        .ext_arb_i   (ext_arb_i),
        .gnt_n_i     (gnt_n_i),
        .alt_gnt_n_i (alt_gnt_n_i),
        .req_i       (req),
        .granted_o   (granted),
        .req_n_o     (req_n_o),
        .alt_req_n_o (alt_req_n_o)
    );

    bpc_req_ctl u_req_ctl (
        .clk        (clk),
        .rst        (rst),
        .granted_i  (granted),
        .idle_i     (idle_i),
        .pend_i     (pend_i),
        .req_o      (req),
        .frame_go_o (frame_go_o)
    );

    bpc_park_ctl u_park_ctl (
        .clk       (clk),
        .rst       (rst),
        .granted_i (granted),
        .idle_i    (idle_i),
        .req_i     (req),
        .drv_o     (drv)
    );

    assign ad_oe_o  = drv.ad;
    assign par_oe_o = drv.par;

    // First clock out of reset shows everything released.
    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (req_n_o && alt_req_n_o && !ad_oe_o && !par_oe_o && !frame_go_o));

endmodule

// File: tb/bus_park_ctl_tb.sv
module bus_park_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 19;

    // Row: [13:10] req tag, [9] ext, [8] pend, [7] gnt_n, [6] alt_gnt_n,
    //      [5] idle, [4] exp req_n, [3] exp alt_req_n, [2] exp ad_oe,
    //      [1] exp par_oe, [0] exp frame_go
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd1,  10'b0_0_1_1_1_1_1_0_0_0},  // R1 quiet, no grant
        {4'd2,  10'b0_1_1_1_1_0_1_0_0_0},  // R2 request raised
        {4'd2,  10'b0_1_1_1_1_0_1_0_0_0},  // R2 request held
        {4'd8,  10'b0_1_0_1_0_0_1_0_0_0},  // R8 grant on busy bus: no start, no park
        {4'd4,  10'b0_1_1_1_1_0_1_0_0_0},  // R4 grant withdrawn, request stays
        {4'd3,  10'b0_1_0_1_1_1_1_0_0_1},  // R3 grant on idle bus -> start
        {4'd11, 10'b0_1_0_1_0_1_1_0_0_0},  // R11 no repeat while pend high
        {4'd5,  10'b0_1_0_1_1_1_1_1_0_0},  // R5 park, still no repeat start
        {4'd6,  10'b0_0_0_1_1_1_1_1_1_0},  // R6 parity one clock later
        {4'd9,  10'b0_1_0_1_1_1_1_1_1_1},  // R9 start from parked
        {4'd7,  10'b0_0_1_1_1_1_1_0_0_0},  // R7 grant lost -> released
        {4'd5,  10'b0_0_0_1_1_1_1_1_0_0},  // R5 park again
        {4'd6,  10'b0_0_0_1_1_1_1_1_1_0},  // R6 parity follows
        {4'd8,  10'b0_0_0_1_0_1_1_0_0_0},  // R8 busy bus releases park
        {4'd10, 10'b1_0_0_1_1_1_1_0_0_0},  // R10 normal grant ignored
        {4'd10, 10'b1_1_0_1_1_1_0_0_0_0},  // R10 request on alternate pin
        {4'd10, 10'b1_1_1_0_1_1_1_0_0_1},  // R10 alternate grant -> start
        {4'd10, 10'b1_0_1_0_1_1_1_1_0_0},  // R10 park via alternate grant
        {4'd7,  10'b0_0_1_1_1_1_1_0_0_0}   // R7 back to normal, no grant
    };

    logic clk = 1'b0;
    logic rst, ext_arb, pend, gnt_n, alt_gnt_n, idle;
    logic req_n, alt_req_n, ad_oe, par_oe, frame_go;
    int   n_run  = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_park_ctl u_dut (
        .clk         (clk),
        .rst         (rst),
        .ext_arb_i   (ext_arb),
        .pend_i      (pend),
        .gnt_n_i     (gnt_n),
        .alt_gnt_n_i (alt_gnt_n),
        .idle_i      (idle),
        .req_n_o     (req_n),
        .alt_req_n_o (alt_req_n),
        .ad_oe_o     (ad_oe),
        .par_oe_o    (par_oe),
        .frame_go_o  (frame_go)
    );

    task automatic check(input int tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {req_n, alt_req_n, ad_oe, par_oe, frame_go};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: {req_n,alt_req_n,ad_oe,par_oe,frame} actual %b expected %b",
                     tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] in);
        {ext_arb, pend, gnt_n, alt_gnt_n, idle} = in;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(5'b0_1_0_1_1);  // pending + grant during reset must not act
        repeat (3) @(posedge clk);
        #1;
        check(1, 5'b11000);   // R1 outputs in reset
        @(negedge clk);
        rst = 1'b0;
        drive(5'b0_0_1_1_1);
        @(posedge clk);
        #1;
        check(1, 5'b11000);   // R1 first clock after reset

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][9:5]);
            @(posedge clk);
            #1;
            check(int'(VEC[i][13:10]), VEC[i][4:0]);
        end

        // R4: long wait with grant on a busy bus only, then start
        @(negedge clk); drive(5'b0_1_1_1_1);
        @(posedge clk); #1; check(4, 5'b01000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); drive(5'b0_1_0_1_0);
            @(posedge clk); #1; check(4, 5'b01000);
        end
        @(negedge clk); drive(5'b0_1_0_1_1);
        @(posedge clk); #1; check(3, 5'b11001);
        // R11: pend stays high, grant and idle present, nothing repeats
        @(negedge clk); drive(5'b0_1_0_1_0);
        @(posedge clk); #1; check(11, 5'b11000);
        @(negedge clk); drive(5'b0_0_1_1_1);
        @(posedge clk); #1; check(11, 5'b11000);

        // R1: reset while parked with parity up
        @(negedge clk); drive(5'b0_0_0_1_1);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk); #1; check(6, 5'b11110);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; check(1, 5'b11000);
        @(negedge clk); rst = 1'b0; drive(5'b0_0_1_1_1);
        @(posedge clk); #1; check(1, 5'b11000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule